// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

A bit-serial cyclic redundancy engine that serves as both generator and checker. A 4-bit select code picks one generator polynomial from a fixed set: two 16-bit codes, the 32-bit Ethernet code in two residue flavours, and three tap sets of degree 56, 48 and 32 that the integrator supplies as parameters. Every polynomial lives right-justified in one shift register that is as wide as the largest degree.

To generate, hold the check-word control high while message bits are clocked in. Then drop it for as many cycles as the polynomial degree. Feedback is then gated off and the remainder streams out MSB first on the serial output, so it can be appended to the message with no outside logic. To check, clock message and check bits in with the control high. The OK output then reports whether the register holds the residue expected for that selection. An asynchronous preset loads a per-polynomial start pattern, and an asynchronous reset clears the register and overrides preset.

Top module: `crc_serial_engine`

## Requirements
- R1: Select codes map as follows: 1 is x^16+x^15+x^2+1, 2 is x^16+x^12+x^5+1, 3 and 4 are the Ethernet polynomial (taps 0x04C11DB7), 5 uses TAPS_56, 6 uses TAPS_48 and 7 uses TAPS_32X. Codes 0 and 8 to 15 use the full register width with no feedback taps. The register then shifts left with zero fill, and din_i has no effect.
- R2: A polynomial of degree d uses register bits d-1..0, and ro_o shows bit d-1. After any rising edge with preset inactive, every bit at or above d is zero, even if the select code has just changed.
- R3: With cwg_i high, on each rising edge the feedback bit is din_i XOR bit d-1. The register shifts left by one, and when the feedback bit is 1 it is XORed with the tap pattern.
- R4: With cwg_i low, feedback is forced to zero and din_i is ignored. The register shifts left with zero fill, so the remainder appears on ro_o MSB first, one bit per edge.
- R5: For every select code except 4, crc_ok_o is high exactly when the register is all zeros. It depends only on the register and the select code, so it holds between edges unless preset or reset acts.
- R6: For select code 4, crc_ok_o is high exactly when the register equals 0xC704DD7B. A frame made of a message followed by the bitwise complement of its check bits yields this value. A frame that carries the plain check bits does not.
- R7: preset_ni low asynchronously loads the register. Within the degree bits the load value is all ones, with these exceptions: code 5 clears the 8 least significant bits, code 4 clears the bits set in 0xC704DD7B (giving 0x38FB2284), and codes 0 and 8 to 15 clear every bit.
- R8: rst_ni low asynchronously clears the whole register and takes priority over preset_ni.
- R9: A checked frame with one bit inverted drives crc_ok_o low after its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge shift clock |
| rst_ni | input | 1 | Asynchronous clear, active low, dominant |
| preset_ni | input | 1 | Asynchronous preset, active low |
| sel_i | input | 4 | Polynomial select code |
| din_i | input | 1 | Serial data or check bits |
| cwg_i | input | 1 | High: feedback on; low: shift remainder out |
| ro_o | output | 1 | Register MSB for the selected degree |
| crc_ok_o | output | 1 | High when the residue matches the selection |

## Verification
The bench builds the block with MAX_W at 56 and passes its own tap values for the 56th-, 48th- and extra 32nd-order slots. A bitwise reference model built from those values predicts every serial output bit for all seven polynomials, including full-width shifts of the 56-bit preset pattern. Because the parameter slots hold known polynomials, generate-then-check round trips, single-bit error detection and the Ethernet complemented-check residue can all be exercised on every selection. A select change from a 56-bit pattern to a 16-bit code shows that the stale upper bits are masked away.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam logic [3:0] SEL_SHIFT   = 4'd0;
  localparam logic [3:0] SEL_CRC16   = 4'd1;
  localparam logic [3:0] SEL_CCITT   = 4'd2;
  localparam logic [3:0] SEL_ETH     = 4'd3;
  localparam logic [3:0] SEL_ETH_RES = 4'd4;
  localparam logic [3:0] SEL_P56     = 4'd5;
  localparam logic [3:0] SEL_P48     = 4'd6;
  localparam logic [3:0] SEL_P32X    = 4'd7;

  localparam logic [15:0] CRC16_TAPS  = 16'h8005;
  localparam logic [15:0] CCITT_TAPS  = 16'h1021;
  localparam logic [31:0] ETH_TAPS    = 32'h04C1_1DB7;
  localparam logic [31:0] ETH_RESIDUE = 32'hC704_DD7B;
endpackage

// File: rtl/crc_poly_decode.sv
module crc_poly_decode
  import crc_eng_pkg::*;
#(
  parameter int          MAX_W    = 56,
  parameter int          IDX_W    = $clog2(MAX_W),
  parameter logic [55:0] TAPS_56  = 56'h80_0000_0000_0095,
  parameter logic [47:0] TAPS_48  = 48'h8000_0000_0005,
  parameter logic [31:0] TAPS_32X = 32'h8E09_0001
) (
  input  logic [3:0]       sel_i,
  output logic [MAX_W-1:0] taps_o,
  output logic [MAX_W-1:0] mask_o,
  output logic [MAX_W-1:0] preset_o,
  output logic [MAX_W-1:0] good_o,
  output logic [IDX_W-1:0] msb_o
);
  localparam int DEG_W = $clog2(MAX_W + 1);

  logic [DEG_W-1:0] deg;
  logic [MAX_W-1:0] clr;

  always_comb begin
    deg    = DEG_W'(MAX_W);
    taps_o = '0;
    good_o = '0;
    clr    = '0;
    case (sel_i)
      SEL_CRC16:   begin deg = DEG_W'(16); taps_o = MAX_W'(CRC16_TAPS); end
      SEL_CCITT:   begin deg = DEG_W'(16); taps_o = MAX_W'(CCITT_TAPS); end
      SEL_ETH:     begin deg = DEG_W'(32); taps_o = MAX_W'(ETH_TAPS); end
      SEL_ETH_RES: begin
        deg    = DEG_W'(32);
        taps_o = MAX_W'(ETH_TAPS);
        good_o = MAX_W'(ETH_RESIDUE);
        clr    = MAX_W'(ETH_RESIDUE);
      end
      SEL_P56:     begin deg = DEG_W'(56); taps_o = MAX_W'(TAPS_56); clr = MAX_W'(8'hFF); end
      SEL_P48:     begin deg = DEG_W'(48); taps_o = MAX_W'(TAPS_48); end
      SEL_P32X:    begin deg = DEG_W'(32); taps_o = MAX_W'(TAPS_32X); end
      default:     clr = '1;  // plain shift, preset clears
    endcase
    for (int i = 0; i < MAX_W; i++) mask_o[i] = (i < int'(deg));
    preset_o = mask_o & ~clr;
    msb_o    = IDX_W'(int'(deg) - 1);
  end
endmodule

// File: rtl/crc_shift_reg.sv
module crc_shift_reg #(
  parameter int MAX_W = 56,
  parameter int IDX_W = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preset_ni,
  input  logic             din_i,
  input  logic             cwg_i,
  input  logic [MAX_W-1:0] taps_i,
  input  logic [MAX_W-1:0] mask_i,
  input  logic [MAX_W-1:0] preset_i,
  input  logic [IDX_W-1:0] msb_i,
  output logic [MAX_W-1:0] state_o,
  output logic             ro_o
);
  logic [MAX_W-1:0] state_q, state_d;
  logic             fb;

  always_comb begin
    fb      = cwg_i & (din_i ^ state_q[msb_i]);
    state_d = ((state_q << 1) & mask_i) ^ (fb ? taps_i : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni or negedge preset_ni) begin
    if (!rst_ni)         state_q <= '0;
    else if (!preset_ni) state_q <= preset_i;
    else                 state_q <= state_d;
  end

  assign state_o = state_q;
  assign ro_o    = state_q[msb_i];
endmodule

// File: rtl/crc_residue_cmp.sv
module crc_residue_cmp #(
  parameter int MAX_W = 56
) (
  input  logic [MAX_W-1:0] state_i,
  input  logic [MAX_W-1:0] good_i,
  output logic             ok_o
);
  assign ok_o = (state_i == good_i);
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
  parameter int          MAX_W    = 56,
  parameter logic [55:0] TAPS_56  = 56'h80_0000_0000_0095,
  parameter logic [47:0] TAPS_48  = 48'h8000_0000_0005,
  parameter logic [31:0] TAPS_32X = 32'h8E09_0001
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       preset_ni,
  input  logic [3:0] sel_i,
  input  logic       din_i,
  input  logic       cwg_i,
  output logic       ro_o,
  output logic       crc_ok_o
);
  localparam int IDX_W = $clog2(MAX_W);

  logic [MAX_W-1:0] taps, mask, preset_pat, good, state_q;
  logic [IDX_W-1:0] msb;

  crc_poly_decode #(
    .MAX_W(MAX_W), .IDX_W(IDX_W),
    .TAPS_56(TAPS_56), .TAPS_48(TAPS_48), .TAPS_32X(TAPS_32X)
  ) u_decode (
    .sel_i   (sel_i),
    .taps_o  (taps),
    .mask_o  (mask),
    .preset_o(preset_pat),
    .good_o  (good),
    .msb_o   (msb)
  );

  crc_shift_reg #(.MAX_W(MAX_W), .IDX_W(IDX_W)) u_sreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_ni(preset_ni),
    .din_i    (din_i),
    .cwg_i    (cwg_i),
    .taps_i   (taps),
    .mask_i   (mask),
    .preset_i (preset_pat),
    .msb_i    (msb),
    .state_o  (state_q),
    .ro_o     (ro_o)
  );

  crc_residue_cmp #(.MAX_W(MAX_W)) u_cmp (
    .state_i(state_q),
    .good_i (good),
    .ok_o   (crc_ok_o)
  );
endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk #(
  parameter int MAX_W = 56
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             preset_ni,
  input logic [3:0]       sel_i,
  input logic             cwg_i,
  input logic             ro_o,
  input logic             crc_ok_o,
  input logic [MAX_W-1:0] state_q,
  input logic [MAX_W-1:0] mask,
  input logic [MAX_W-1:0] preset_pat
);
  a_r4_gated_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cwg_i && preset_ni) |=> (!preset_ni || state_q == (($past(state_q) << 1) & $past(mask))));

  a_r7_preset_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preset_ni |-> (state_q == preset_pat));

  a_r5_ok_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(state_q) && $stable(sel_i)) |-> $stable(crc_ok_o));

  a_r2_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_ni |=> (!preset_ni || (state_q & ~$past(mask)) == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_clear: assert (state_q == '0 && ro_o == 1'b0);
    end
  end
endmodule

bind crc_serial_engine crc_serial_engine_chk #(.MAX_W(MAX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .preset_ni (preset_ni),
  .sel_i     (sel_i),
  .cwg_i     (cwg_i),
  .ro_o      (ro_o),
  .crc_ok_o  (crc_ok_o),
  .state_q   (state_q),
  .mask      (mask),
  .preset_pat(preset_pat)
);

// File: tb/crc_serial_engine_bench.sv
module crc_serial_engine_bench;
  localparam logic [55:0] T56  = 56'h40_0000_0010_0825;
  localparam logic [47:0] T48  = 48'h0000_8000_0403;
  localparam logic [31:0] T32X = 32'h8E09_0001;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b1, preset_n = 1'b1, din = 1'b0, cwg = 1'b1;
  logic [3:0] sel = 4'd1;
  logic       ro, ok;

  crc_serial_engine #(.MAX_W(56), .TAPS_56(T56), .TAPS_48(T48), .TAPS_32X(T32X))
  u_crc_serial_engine (
    .clk_i(clk), .rst_ni(rst_n), .preset_ni(preset_n), .sel_i(sel),
    .din_i(din), .cwg_i(cwg), .ro_o(ro), .crc_ok_o(ok)
  );

  typedef struct {bit is_ok; bit exp; string req;} exp_t;
  exp_t sb[$];

  int          checks = 0, errors = 0, cur = 1;
  logic [55:0] mdl = '0, rem = '0;
  bit          msg[24];

  function automatic int bdeg(int c);
    case (c)
      1, 2:    return 16;
      3, 4, 7: return 32;
      6:       return 48;
      default: return 56;
    endcase
  endfunction

  function automatic logic [55:0] bmask(int c);
    return (bdeg(c) == 56) ? '1 : ((56'(1) << bdeg(c)) - 56'(1));
  endfunction

  function automatic logic [55:0] btaps(int c);
    case (c)
      1:       return 56'h8005;
      2:       return 56'h1021;
      3, 4:    return 56'h04C1_1DB7;
      5:       return T56;
      6:       return 56'(T48);
      7:       return 56'(T32X);
      default: return '0;
    endcase
  endfunction

  function automatic logic [55:0] bpreset(int c);
    if (c == 0 || c > 7) return '0;
    if (c == 4) return bmask(c) & ~56'hC704_DD7B;
    if (c == 5) return bmask(c) & ~56'hFF;
    return bmask(c);
  endfunction

  function automatic logic [55:0] bgood(int c);
    return (c == 4) ? 56'hC704_DD7B : '0;
  endfunction

  function automatic logic [55:0] mstep(logic [55:0] s, bit d, bit c, int code);
    bit fb;
    fb = c & (d ^ s[bdeg(code)-1]);
    s  = (s << 1) & bmask(code);
    if (fb) s = s ^ btaps(code);
    return s;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, e.is_ok ? ok : ro, e.exp);
    end
  end

  task automatic step(bit d, bit c, string req, bit w);
    din = d; cwg = c;
    @(posedge clk);
    mdl = mstep(mdl, d, c, cur);
    if (w) begin
      sb.push_back('{is_ok: 1'b0, exp: mdl[bdeg(cur)-1], req: req});
      sb.push_back('{is_ok: 1'b1, exp: (mdl == bgood(cur)), req: req});
    end
    @(negedge clk);
  endtask

  task automatic do_preset(int c);
    #1 sel = 4'(c); cur = c;
    #1 preset_n = 1'b0; mdl = bpreset(c);
    #2 chk("R7", ro, mdl[bdeg(c)-1]);
    chk("R7", ok, mdl == bgood(c));
    @(posedge clk);
    @(negedge clk);
    preset_n = 1'b1;
  endtask

  task automatic gen_rem(int c);
    do_preset(c);
    for (int i = 0; i < 24; i++) step(msg[i], 1'b1, "R3", 1'b1);
    chk("R4", ro, mdl[bdeg(c)-1]);
    rem = mdl;
    for (int i = 0; i < bdeg(c); i++) step(bit'($urandom), 1'b0, "R4", 1'b1);
  endtask

  task automatic frame(int c, bit flip, bit inv);
    do_preset(c);
    for (int i = 0; i < 24; i++) step(msg[i] ^ (flip && i == 5), 1'b1, "R3", 1'b0);
    for (int i = 0; i < bdeg(c); i++) step(rem[bdeg(c)-1-i] ^ inv, 1'b1, "R5", 1'b1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int codes[6] = '{1, 2, 3, 5, 6, 7};
    foreach (msg[i]) msg[i] = bit'($urandom);
    #1 rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8", ro, 1'b0);
    chk("R8", ok, 1'b1);
    // R8: reset dominates preset
    #1 sel = 4'd5; cur = 5;
    #1 preset_n = 1'b0;
    #2 chk("R8", ro, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R8", ro, 1'b0);
    preset_n = 1'b1;
    #1 rst_n = 1'b1; mdl = '0;
    @(negedge clk);

    // R1: codes with no taps just shift, data ignored
    do_preset(5);
    #1 sel = 4'd0; cur = 0;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, "R1", 1'b1);
    do_preset(11);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R1", 1'b1);
    chk("R1", ok, 1'b1);

    // R7: preset patterns shifted out
    do_preset(5);
    for (int i = 0; i < 56; i++) step(bit'($urandom), 1'b0, "R7", 1'b1);
    do_preset(4);
    for (int i = 0; i < 32; i++) step(bit'($urandom), 1'b0, "R7", 1'b1);

    // R1 R3 R4 R5 R9 across polynomials
    foreach (codes[k]) begin
      gen_rem(codes[k]);
      chk("R4", ok, 1'b1);
      frame(codes[k], 1'b0, 1'b0);
      chk("R5", ok, 1'b1);
      frame(codes[k], 1'b1, 1'b0);
      chk("R9", ok, 1'b0);
    end

    // R6: Ethernet residue check
    gen_rem(4);
    frame(4, 1'b0, 1'b1);
    chk("R6", ok, 1'b1);
    frame(4, 1'b0, 1'b0);
    chk("R6", ok, 1'b0);
    frame(4, 1'b1, 1'b1);
    chk("R9", ok, 1'b0);

    // R2: switch from 56-bit pattern to a 16-bit code
    do_preset(5);
    #1 sel = 4'd1; cur = 1;
    #1 chk("R2", ro, mdl[15]);
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, "R2", 1'b1);
    chk("R2", ok, 1'b1);

    // R8: reset mid-message
    do_preset(3);
    for (int i = 0; i < 8; i++) step(msg[i], 1'b1, "R3", 1'b1);
    #1 rst_n = 1'b0; mdl = '0;
    #2 chk("R8", ok, 1'b1);
    chk("R8", ro, 1'b0);
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule